// File: doc/BRIEF.md
# Bus Error Transaction Header Logger

This block watches the phases of each transaction on a parallel PCI or PCI-X style bus. It keeps a shadow copy of the header of the transaction in progress: the address, the command nibbles and the attribute word. When an uncorrectable error is signalled, it copies that header into a 128-bit read-only log in a single clock.

After a capture, the log is frozen. Later error pulses are ignored until software clears the status bit that caused the capture. The block remembers the index of that causing status bit. A clear strobe re-arms the log only when it carries the same index. Clearing does not erase the log. The old contents stay readable until the next capture replaces them.

The log layout is fixed. Bits 127:64 hold the address. Bits 63:44 read as zero. Bits 43:40 hold the command nibble from the second phase of a dual-address cycle. Bits 39:36 hold the command nibble from the first address phase. Bits 35:0 hold the attribute word, with C/BE in bits 35:32 and AD in bits 31:0.

Top module: `hdr_err_log`

## Requirements
- R1: After reset, every bit of `log_q` is zero and the log is armed, so the first error pulse is captured.
- R2: When `err_pulse` is high at a clock edge and the log is armed, `log_q` shows the shadow header at the next sample. The shadow header is the value it had before that edge.
- R3: A first-address strobe loads `ad` into address bits 31:0 and clears address bits 63:32. A second-address strobe then loads `ad` into address bits 63:32 (log bits 127:96). A single-address transaction therefore logs zero in its upper 32 address bits.
- R4: Log bits 39:36 hold `cbe` from the first-address strobe. Log bits 43:40 hold `cbe` from the second-address strobe. Bits 43:40 are zero for a single-address transaction.
- R5: An attribute strobe with `pcix_mode` high sets log bits 35:32 to `cbe` and log bits 31:0 to `ad`. An attribute strobe with `pcix_mode` low sets all 36 attribute bits to zero.
- R6: Log bits 63:44 are always zero.
- R7: Once a capture has happened, later error pulses leave `log_q` unchanged.
- R8: A `clr_pulse` whose `clr_idx` equals the `err_idx` of the capture re-arms the log. The log keeps its contents until the next error captures a new header.
- R9: A `clr_pulse` whose index differs from the recorded cause does not re-arm the log.
- R10: A first-address strobe starts a new header. It zeroes the shadow's upper address, its dual-address command and its attribute.
- R11: An error pulse that arrives while the log is locked is ignored, even in the cycle where a matching clear re-arms the log.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pcix_mode | input | 1 | 1 = PCI-X mode, 0 = conventional PCI mode |
| addr1_vld | input | 1 | First address phase strobe |
| addr2_vld | input | 1 | Second (dual-address) phase strobe |
| attr_vld | input | 1 | Attribute phase strobe |
| ad | input | 32 | Address/data bus value |
| cbe | input | 4 | Command/byte-enable bus value |
| err_pulse | input | 1 | Uncorrectable error detected |
| err_idx | input | 3 | Status bit index of the error |
| clr_pulse | input | 1 | Software cleared a status bit |
| clr_idx | input | 3 | Index of the cleared status bit |
| log_q | output | 128 | Header log |

## Verification
A corrupted shadow field stays hidden until the next error capture. At that point it shows up in the matching log field one cycle after the error pulse. A wrong lock or cause state shows up one cycle after the next error pulse. If the block fails to capture, the log stays the same when it should change. If it captures when it should stay locked, the log changes when it should hold. For that reason the stimulus keeps firing errors after matching, mismatching and simultaneous clears, so each lock fault reaches the ports within a few cycles.

// File: rtl/hdr_err_log.sv
module hdr_err_log #(
  parameter int AD_W  = 32,
  parameter int CBE_W = 4,
  parameter int IDX_W = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                pcix_mode,
  input  logic                addr1_vld,
  input  logic                addr2_vld,
  input  logic                attr_vld,
  input  logic [AD_W-1:0]     ad,
  input  logic [CBE_W-1:0]    cbe,
  input  logic                err_pulse,
  input  logic [IDX_W-1:0]    err_idx,
  input  logic                clr_pulse,
  input  logic [IDX_W-1:0]    clr_idx,
  output logic [4*AD_W-1:0]   log_q
);
  localparam int ATTR_W = AD_W + CBE_W;
  localparam int RSV_W  = 2*AD_W - ATTR_W - 2*CBE_W;

  logic [2*AD_W-1:0]  sh_addr;
  logic [CBE_W-1:0]   sh_cmd, sh_dac;
  logic [ATTR_W-1:0]  sh_attr;
  logic               locked;
  logic [IDX_W-1:0]   cause;
  logic               rearm;

  assign rearm = locked && clr_pulse && (clr_idx == cause);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_addr <= '0;
      sh_cmd  <= '0;
      sh_dac  <= '0;
      sh_attr <= '0;
    end else begin
      if (addr1_vld) begin
        sh_addr <= {{AD_W{1'b0}}, ad};
        sh_cmd  <= cbe;
        sh_dac  <= '0;
        sh_attr <= '0;
      end
      if (addr2_vld) begin
        sh_addr[2*AD_W-1:AD_W] <= ad;
        sh_dac                 <= cbe;
      end
      if (attr_vld)
        sh_attr <= pcix_mode ? {cbe, ad} : '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      log_q  <= '0;
      locked <= 1'b0;
      cause  <= '0;
    end else if (err_pulse && !locked) begin
      log_q  <= {sh_addr, {RSV_W{1'b0}}, sh_dac, sh_cmd, sh_attr};
      locked <= 1'b1;
      cause  <= err_idx;
    end else if (rearm) begin
      locked <= 1'b0;
    end
  end

  a_r7_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    locked |=> $stable(log_q));
  a_r2_locks_on_capture: assert property (@(posedge clk) disable iff (!rst_n)
    (err_pulse && !locked) |=> locked);
  a_r8_rearm: assert property (@(posedge clk) disable iff (!rst_n)
    rearm |=> !locked);
  a_r9_no_stray_rearm: assert property (@(posedge clk) disable iff (!rst_n)
    (locked && !(clr_pulse && clr_idx == cause)) |=> locked);
  a_r6_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
    log_q[2*AD_W-ATTR_W-2*CBE_W+ATTR_W+2*CBE_W-1 -: RSV_W] == '0);
  a_r2_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!locked && !err_pulse) |=> $stable(log_q));
endmodule

// File: tb/hdr_err_log_tb.sv
module hdr_err_log_tb;
  logic clk = 0, rst_n = 0;
  logic pcix_mode = 0, addr1_vld = 0, addr2_vld = 0, attr_vld = 0;
  logic [31:0] ad = 0;
  logic [3:0] cbe = 0;
  logic err_pulse = 0, clr_pulse = 0;
  logic [2:0] err_idx = 0, clr_idx = 0;
  logic [127:0] log_q;

  int checks = 0, errors = 0;
  bit done = 0;

  logic [63:0] m_addr;
  logic [3:0]  m_cmd, m_dac;
  logic [35:0] m_attr;
  logic [127:0] m_log;
  logic m_lock;
  logic [2:0] m_cause;

  always #5 clk = ~clk;

  hdr_err_log u_dut (.clk, .rst_n, .pcix_mode, .addr1_vld, .addr2_vld, .attr_vld,
    .ad, .cbe, .err_pulse, .err_idx, .clr_pulse, .clr_idx, .log_q);

  function automatic logic [127:0] pack_log(logic [63:0] a, logic [3:0] d,
                                            logic [3:0] c, logic [35:0] t);
    return {a, 20'h0, d, c, t};
  endfunction

  task automatic chk(string tag, logic [127:0] act, logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic model_edge();
    logic [127:0] nl = m_log;
    logic nk = m_lock;
    logic [2:0] nc = m_cause;
    if (err_pulse && !m_lock) begin
      nl = pack_log(m_addr, m_dac, m_cmd, m_attr); nk = 1; nc = err_idx;
    end else if (m_lock && clr_pulse && clr_idx == m_cause) nk = 0;
    if (addr1_vld) begin m_addr = {32'h0, ad}; m_cmd = cbe; m_dac = 0; m_attr = 0; end
    if (addr2_vld) begin m_addr[63:32] = ad; m_dac = cbe; end
    if (attr_vld) m_attr = pcix_mode ? {cbe, ad} : 36'h0;
    m_log = nl; m_lock = nk; m_cause = nc;
  endtask

  task automatic step(string tag);
    @(negedge clk);
    model_edge();
    chk(tag, log_q, m_log);
    addr1_vld = 0; addr2_vld = 0; attr_vld = 0; err_pulse = 0; clr_pulse = 0;
  endtask

  task automatic a1(logic [31:0] a, logic [3:0] c); addr1_vld = 1; ad = a; cbe = c; endtask
  task automatic a2(logic [31:0] a, logic [3:0] c); addr2_vld = 1; ad = a; cbe = c; endtask
  task automatic at(logic [31:0] a, logic [3:0] c); attr_vld = 1; ad = a; cbe = c; endtask
  task automatic er(logic [2:0] i); err_pulse = 1; err_idx = i; endtask
  task automatic cl(logic [2:0] i); clr_pulse = 1; clr_idx = i; endtask

  initial begin
    #2_000_000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    m_addr = 0; m_cmd = 0; m_dac = 0; m_attr = 0; m_log = 0; m_lock = 0; m_cause = 0;
    repeat (3) @(negedge clk);
    chk("R1 reset log", log_q, 128'h0);
    rst_n = 1;
    @(negedge clk);

    pcix_mode = 1;
    a1(32'hCAFE_0010, 4'h6); step("R3");
    at(32'h1234_5678, 4'hA); step("R5");
    er(3'd2); step("R2");
    chk("R3 single addr upper zero", log_q[127:64], 64'h0000_0000_CAFE_0010);
    chk("R4 cmd", {124'h0, log_q[39:36]}, 128'h6);
    chk("R4 dac zero single", {124'h0, log_q[43:40]}, 128'h0);
    chk("R5 attr", {92'h0, log_q[35:0]}, {92'h0, 4'hA, 32'h1234_5678});
    chk("R6 reserved", {108'h0, log_q[63:44]}, 128'h0);
    chk("R1 first capture armed", {127'h0, log_q != 0}, 128'h1);

    a1(32'h0000_0044, 4'hD); step("R7");
    a2(32'h0000_0009, 4'h7); step("R7");
    er(3'd5); step("R7");
    chk("R7 locked ignores error", log_q[127:64], 64'h0000_0000_CAFE_0010);

    cl(3'd4); step("R9");
    er(3'd4); step("R9");
    chk("R9 wrong clear stays locked", log_q[127:64], 64'h0000_0000_CAFE_0010);

    cl(3'd2); step("R8");
    chk("R8 log held after clear", log_q[127:64], 64'h0000_0000_CAFE_0010);
    er(3'd1); step("R8");
    chk("R3 dac upper", log_q[127:64], 64'h0000_0009_0000_0044);
    chk("R4 dac cmd", {124'h0, log_q[43:40]}, 128'h7);
    chk("R10 attr cleared by addr1", {92'h0, log_q[35:0]}, 128'h0);

    pcix_mode = 0;
    er(3'd3); cl(3'd1); step("R11");
    chk("R11 error ignored during rearm", log_q[127:64], 64'h0000_0009_0000_0044);
    at(32'hFFFF_FFFF, 4'hF); step("R5");
    er(3'd6); a1(32'h5555_0000, 4'h3); step("R11");
    chk("R5 pci attr zero", {92'h0, log_q[35:0]}, 128'h0);
    chk("R11 pre-edge shadow", log_q[127:64], 64'h0000_0009_0000_0044);
    cl(3'd6); step("R8");
    er(3'd0); step("R10");
    chk("R10 new header", log_q[127:64], 64'h0000_0000_5555_0000);

    void'($urandom(32'd1234));
    for (int i = 0; i < 4000; i++) begin
      pcix_mode = ($urandom % 4) != 0;
      ad = $urandom; cbe = 4'($urandom);
      addr1_vld = ($urandom % 5) == 0;
      addr2_vld = ($urandom % 6) == 0;
      attr_vld  = ($urandom % 5) == 0;
      err_pulse = ($urandom % 7) == 0; err_idx = 3'($urandom);
      clr_pulse = ($urandom % 5) == 0;
      clr_idx = (($urandom % 2) == 0) ? m_cause : 3'($urandom);
      step("R2 random");
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule